// File: doc/BRIEF.md
# Two-Level Receive Frame Buffer

This block sits between a serial receiver engine and the CPU register file. Each frame the engine completes is written as one entry: a low data byte, a ninth data bit, a framing-error flag and a parity-error flag. The block adds an overrun flag to each entry. Every flag travels with its own byte through a small FIFO, two entries deep by default. Software sees the head entry through two side-effect-free views, the status flags and the ninth bit. It must read these first. It then issues a data read, which returns the low byte and retires the whole entry.

The block drives a level receive-complete flag whenever unread data is held. An interrupt line repeats that flag only while the local enable and the global enable are both set. Dropping the receiver enable empties the buffer. A frame that arrives with both entries occupied is discarded, and the newest stored entry is marked as overrun, so software meets the mark just after the last good frame.

Top module: `rxbuf_stat`

## Requirements
- R1: While `rst_n` is low and after it rises, `rxc`, `irq`, `rd_byte` and all four head outputs are 0.
- R2: Frames are read in arrival order. The byte of the head entry appears on `rd_byte` one clock after the cycle in which `rd_pop` is high, and `rd_byte` holds its value in every cycle without a pop.
- R3: `head_bit9`, `head_ferr`, `head_perr` and `head_ovr` show the entry at the head of the FIFO combinationally, and they change only when that entry is popped.
- R4: `rxc` is 1 exactly while at least one unread entry is held. The buffer holds DEPTH (default 2) entries.
- R5: A `wr_valid` pulse that finds the buffer full, with no pop in the same cycle, is discarded. The newest stored entry gets its overrun flag set, and the older entry is left unchanged.
- R6: A write and a pop in the same cycle are both carried out, whether one entry or DEPTH entries are held, and the occupancy is unchanged.
- R7: A pop while the buffer is empty leaves `rd_byte` unchanged and moves no pointer.
- R8: A clock edge with `rx_en` low empties the buffer, so `rxc` is 0 after it. Writes are ignored while `rx_en` is low.
- R9: `irq` is 1 exactly when `rxc`, `irq_en` and `gie` are all 1.
- R10: While the buffer is empty, all four head outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| wr_valid | input | 1 | One-cycle strobe: a finished frame is presented |
| wr_data | input | DATA_W | Low data bits of the frame |
| wr_bit9 | input | 1 | Ninth data bit of the frame |
| wr_ferr | input | 1 | Framing error seen on this frame |
| wr_perr | input | 1 | Parity error seen on this frame |
| rd_pop | input | 1 | Data read strobe; pops the head entry |
| irq_en | input | 1 | Receive-complete interrupt enable |
| gie | input | 1 | Global interrupt enable |
| rd_byte | output | DATA_W | Byte returned by the last data read |
| head_bit9 | output | 1 | Ninth bit of the head entry |
| head_ferr | output | 1 | Framing error flag of the head entry |
| head_perr | output | 1 | Parity error flag of the head entry |
| head_ovr | output | 1 | Overrun flag of the head entry |
| rxc | output | 1 | Receive complete: unread data present |
| irq | output | 1 | Gated receive-complete interrupt level |

## Verification
A write or a pop takes effect at the first rising edge after its strobe. From that edge, `rxc`, the head views and `irq` follow through logic alone. `rd_byte` is loaded at the same edge, and a flush acts at the first edge with `rx_en` low. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge, so every result is read half a cycle after the edge that produced it. `irq` is sampled again after the enables change, and that change needs no clock edge.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
   // Per-entry side information carried alongside the data byte
   typedef struct packed {
      logic bit9;
      logic ferr;
      logic perr;
      logic ovr;
   } rxbuf_tag_t;

   localparam rxbuf_tag_t RXBUF_TAG_NONE = '{bit9: 1'b0, ferr: 1'b0, perr: 1'b0, ovr: 1'b0};
endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl #(
   parameter int DEPTH = 2,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             push_req,
   input  logic             pop_req,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W-1:0] last_ptr,
   output logic             push_ok,
   output logic             pop_ok,
   output logic             ovr_hit,
   output logic             empty
);
   logic [CNT_W-1:0] count;
   logic             full;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty    = (count == '0);
   assign full     = (count == CNT_W'(DEPTH));
   assign pop_ok   = rx_en & pop_req & ~empty;
   assign push_ok  = rx_en & push_req & (~full | pop_ok);
   assign ovr_hit  = rx_en & push_req & full & ~pop_ok;
   assign last_ptr = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || !rx_en) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= step(wr_ptr);
         if (pop_ok)  rd_ptr <= step(rd_ptr);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store
   import rxbuf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_ok,
   input  logic              pop_ok,
   input  logic              ovr_hit,
   input  logic              empty,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [PTR_W-1:0]  rd_ptr,
   input  logic [PTR_W-1:0]  last_ptr,
   input  logic [DATA_W-1:0] in_data,
   input  rxbuf_tag_t        in_tag,
   output logic [DATA_W-1:0] rd_byte,
   output rxbuf_tag_t        head_tag
);
   logic [DATA_W-1:0] slot_data [DEPTH];
   rxbuf_tag_t        slot_tag  [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_data[i] <= '0;
            slot_tag[i]  <= RXBUF_TAG_NONE;
         end else if (push_ok && wr_ptr == PTR_W'(i)) begin
            slot_data[i] <= in_data;
            slot_tag[i]  <= '{bit9: in_tag.bit9, ferr: in_tag.ferr,
                              perr: in_tag.perr, ovr: 1'b0};
         end else if (ovr_hit && last_ptr == PTR_W'(i)) begin
            slot_tag[i].ovr <= 1'b1;
         end
      end
   end

   assign head_tag = empty ? RXBUF_TAG_NONE : slot_tag[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_byte <= '0;
      else if (pop_ok) rd_byte <= slot_data[rd_ptr];
   end
endmodule

// File: rtl/rxbuf_irq.sv
module rxbuf_irq (
   input  logic empty,
   input  logic irq_en,
   input  logic gie,
   output logic rxc,
   output logic irq
);
   assign rxc = ~empty;
   assign irq = rxc & irq_en & gie;
endmodule

// File: rtl/rxbuf_stat.sv
module rxbuf_stat
   import rxbuf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_bit9,
   input  logic              wr_ferr,
   input  logic              wr_perr,
   input  logic              rd_pop,
   input  logic              irq_en,
   input  logic              gie,
   output logic [DATA_W-1:0] rd_byte,
   output logic              head_bit9,
   output logic              head_ferr,
   output logic              head_perr,
   output logic              head_ovr,
   output logic              rxc,
   output logic              irq
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxbuf_stat: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rxbuf_stat: DATA_W must be positive");
   end

   logic [PTR_W-1:0] wr_ptr, rd_ptr, last_ptr;
   logic             push_ok, pop_ok, ovr_hit, empty;
   rxbuf_tag_t       in_tag, head_tag;

   assign in_tag = '{bit9: wr_bit9, ferr: wr_ferr, perr: wr_perr, ovr: 1'b0};

   rxbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_en    (rx_en),
      .push_req (wr_valid),
      .pop_req  (rd_pop),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .last_ptr (last_ptr),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .ovr_hit  (ovr_hit),
      .empty    (empty)
   );

   rxbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .ovr_hit  (ovr_hit),
      .empty    (empty),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .last_ptr (last_ptr),
      .in_data  (wr_data),
      .in_tag   (in_tag),
      .rd_byte  (rd_byte),
      .head_tag (head_tag)
   );

   rxbuf_irq u_irq (
      .empty  (empty),
      .irq_en (irq_en),
      .gie    (gie),
      .rxc    (rxc),
      .irq    (irq)
   );

   assign head_bit9 = head_tag.bit9;
   assign head_ferr = head_tag.ferr;
   assign head_perr = head_tag.perr;
   assign head_ovr  = head_tag.ovr;
endmodule

// File: rtl/rxbuf_stat_chk.sv
module rxbuf_stat_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en,
   input logic              wr_valid,
   input logic              rd_pop,
   input logic              irq_en,
   input logic              gie,
   input logic [DATA_W-1:0] rd_byte,
   input logic              head_bit9,
   input logic              head_ferr,
   input logic              head_perr,
   input logic              head_ovr,
   input logic              rxc,
   input logic              irq
);
   // R4: an accepted or dropped write leaves unread data behind
   a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && wr_valid) |=> rxc);

   // R2: rd_byte moves only on a pop
   a_r2_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_pop |=> $stable(rd_byte));

   // R7: pop on an empty buffer keeps the last byte
   a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && !rxc) |=> ($stable(rd_byte) && !rxc));

   // R8: disable flushes
   a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rxc);

   // R9: interrupt needs all three conditions
   a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (rxc && irq_en && gie));

   // R10: empty buffer shows clear head views
   a_r10_empty_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !rxc |-> !(head_bit9 || head_ferr || head_perr || head_ovr));

   // R3: head views hold without a pop, while enabled and not written when empty
   a_r3_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rxc && rx_en && !rd_pop) |=> (!rx_en || (rxc && $stable(head_bit9) && $stable(head_ferr)
                                  && $stable(head_perr))));
endmodule

bind rxbuf_stat rxbuf_stat_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_en     (rx_en),
   .wr_valid  (wr_valid),
   .rd_pop    (rd_pop),
   .irq_en    (irq_en),
   .gie       (gie),
   .rd_byte   (rd_byte),
   .head_bit9 (head_bit9),
   .head_ferr (head_ferr),
   .head_perr (head_perr),
   .head_ovr  (head_ovr),
   .rxc       (rxc),
   .irq       (irq)
);

// File: tb/rxbuf_stat_tb.sv
module rxbuf_stat_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_bit9 = 1'b0;
   logic       wr_ferr = 1'b0;
   logic       wr_perr = 1'b0;
   logic       rd_pop = 1'b0;
   logic       irq_en = 1'b0;
   logic       gie = 1'b0;
   logic [7:0] rd_byte;
   logic       head_bit9, head_ferr, head_perr, head_ovr, rxc, irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   rxbuf_stat u_dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_bit9(wr_bit9), .wr_ferr(wr_ferr), .wr_perr(wr_perr),
      .rd_pop(rd_pop), .irq_en(irq_en), .gie(gie), .rd_byte(rd_byte),
      .head_bit9(head_bit9), .head_ferr(head_ferr), .head_perr(head_perr),
      .head_ovr(head_ovr), .rxc(rxc), .irq(irq)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // head view packed as {bit9, ferr, perr, ovr}
   function automatic int head4();
      return {28'd0, head_bit9, head_ferr, head_perr, head_ovr};
   endfunction

   // one-cycle strobes, from a falling edge to the next falling edge
   task automatic cyc(input bit wv, input logic [7:0] d, input logic [2:0] bfp, input bit pop);
      wr_valid = wv; wr_data = d; {wr_bit9, wr_ferr, wr_perr} = bfp; rd_pop = pop;
      @(negedge clk);
      wr_valid = 1'b0; rd_pop = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "rxc", rxc, 0);
      chk("R1", "irq", irq, 0);
      chk("R1", "rd_byte", rd_byte, 0);
      chk("R1", "head", head4(), 0);
   endtask

   task automatic t_order_flags();
      cyc(1, 8'hA1, 3'b101, 0);
      chk("R4", "rxc after one write", rxc, 1);
      chk("R3", "head of first", head4(), 4'b1010);
      cyc(1, 8'hB2, 3'b011, 0);
      chk("R3", "head unchanged by second write", head4(), 4'b1010);
      cyc(0, 0, 0, 1);
      chk("R2", "first byte", rd_byte, 8'hA1);
      chk("R3", "head of second", head4(), 4'b0110);
      cyc(0, 0, 0, 0);
      chk("R2", "byte held", rd_byte, 8'hA1);
      cyc(0, 0, 0, 1);
      chk("R2", "second byte", rd_byte, 8'hB2);
      chk("R4", "rxc empty", rxc, 0);
      chk("R10", "head empty", head4(), 0);
   endtask

   task automatic t_overrun();
      cyc(1, 8'h11, 3'b000, 0);
      cyc(1, 8'h22, 3'b000, 0);
      cyc(1, 8'h33, 3'b111, 0);
      chk("R5", "older entry no ovr", head4(), 0);
      cyc(0, 0, 0, 1);
      chk("R5", "older byte", rd_byte, 8'h11);
      chk("R5", "newest flagged ovr", head4(), 4'b0001);
      cyc(0, 0, 0, 1);
      chk("R5", "newest byte kept", rd_byte, 8'h22);
      chk("R5", "dropped frame absent", rxc, 0);
   endtask

   task automatic t_same_cycle();
      cyc(1, 8'h44, 3'b000, 0);
      cyc(1, 8'h55, 3'b100, 1);
      chk("R6", "pop with one held", rd_byte, 8'h44);
      chk("R6", "write kept", head4(), 4'b1000);
      cyc(1, 8'h66, 3'b000, 0);
      cyc(1, 8'h77, 3'b010, 1);
      chk("R6", "pop with full", rd_byte, 8'h55);
      chk("R6", "no ovr when popped", head4(), 0);
      cyc(0, 0, 0, 1);
      chk("R6", "third byte", rd_byte, 8'h66);
      chk("R6", "fourth head", head4(), 4'b0100);
      cyc(0, 0, 0, 1);
      chk("R6", "fourth byte", rd_byte, 8'h77);
      chk("R6", "drained", rxc, 0);
   endtask

   task automatic t_empty_pop();
      cyc(0, 0, 0, 1);
      chk("R7", "byte held on empty pop", rd_byte, 8'h77);
      chk("R7", "still empty", rxc, 0);
      cyc(1, 8'h88, 3'b000, 0);
      cyc(0, 0, 0, 1);
      chk("R7", "pointers intact", rd_byte, 8'h88);
   endtask

   task automatic t_flush();
      cyc(1, 8'h99, 3'b100, 0);
      cyc(1, 8'hAA, 3'b000, 0);
      rx_en = 1'b0;
      cyc(0, 0, 0, 0);
      chk("R8", "flushed", rxc, 0);
      cyc(1, 8'hBB, 3'b000, 0);
      chk("R8", "write ignored", rxc, 0);
      rx_en = 1'b1;
      cyc(0, 0, 0, 0);
      chk("R8", "empty after enable", rxc, 0);
      cyc(1, 8'hCC, 3'b000, 0);
      cyc(0, 0, 0, 1);
      chk("R8", "fresh byte", rd_byte, 8'hCC);
      chk("R8", "one entry only", rxc, 0);
   endtask

   task automatic t_irq();
      irq_en = 1'b1; gie = 1'b1; #1;
      chk("R9", "empty no irq", irq, 0);
      cyc(1, 8'hDD, 3'b000, 0);
      chk("R9", "irq on", irq, 1);
      gie = 1'b0; #1;
      chk("R9", "gie off", irq, 0);
      gie = 1'b1; irq_en = 1'b0; #1;
      chk("R9", "enable off", irq, 0);
      irq_en = 1'b1; #1;
      chk("R9", "irq back", irq, 1);
      @(negedge clk);
      cyc(0, 0, 0, 1);
      chk("R9", "irq off when empty", irq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1; rx_en = 1'b1;
      @(negedge clk);
      t_reset();
      t_order_flags();
      t_overrun();
      t_same_cycle();
      t_empty_pop();
      t_flush();
      t_irq();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule